// File: doc/BRIEF.md
# NRZI Decoder with Self-Synchronizing Descrambler

This block restores the payload bit stream from a reclocked serial line that was scrambled with the generator x^9 + x^4 + 1 and then NRZI coded. One received bit is taken on each clock where the bit-valid strobe is high. Decoding has two stages. First, NRZI is turned back into NRZ by XORing each received bit with the received bit before it; this is the x + 1 factor. Second, the NRZ stream is multiplied by x^9 + x^4 + 1 modulo 2. Neither stage has a feedback path, so a bit error or an unknown starting state clears itself after ten valid bits.

The block sits between a clock-recovery front end and a word aligner. A registered copy of each received coded bit comes out beside the decoded bit, so a repeater path can pass the line on unchanged. A settling flag marks the outputs whose value still depends on the state loaded at reset.

Top module: `nrzi_descrambler`

## Requirements
- R1: While rst_ni is low and on the first cycle after it, bit_vld_o, bit_o and rpt_bit_o are 0 and settle_o is 1.
- R2: The NRZ bit of a valid cycle is bit_i XOR the bit_i of the previous valid cycle. That history is 0 after reset, so inputs 1,0 give NRZ 1,1.
- R3: The decoded bit is NRZ(k) XOR NRZ(k-4) XOR NRZ(k-9). Delays count valid bits, and stages not yet filled after reset read 0.
- R4: The decoded bit of a valid input cycle shows on bit_o one clock later, and bit_vld_o is bit_vld_i delayed by exactly one clock.
- R5: A cycle with bit_vld_i low changes no internal state. On the next clock bit_vld_o is 0 and bit_o and rpt_bit_o hold their values, whatever bit_i was.
- R6: rpt_bit_o is the bit_i of the most recent valid cycle and appears one clock after it.
- R7: settle_o is 1 alongside the outputs of the first 10 valid inputs after reset, and 0 from the 11th onward until the next reset.
- R8: Paired with a scrambler that uses x^9 + x^4 + 1 feedback followed by NRZI coding, from any starting state, bit_o equals the original data from the 11th valid bit onward, long runs of zeros included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_vld_i | input | 1 | Received bit is valid this cycle |
| bit_i | input | 1 | Received NRZI-coded bit |
| bit_o | output | 1 | Descrambled bit |
| bit_vld_o | output | 1 | bit_o is valid |
| rpt_bit_o | output | 1 | Registered copy of the received coded bit |
| settle_o | output | 1 | Current output still depends on the reset state |

## Verification
Every result is due one clock after the valid input that produced it: bit_o, bit_vld_o, rpt_bit_o and settle_o all come from a single output register stage. The bench drives inputs on the falling edge, waits for one rising edge, and samples on the next falling edge, before it drives the next input. In each idle cycle it checks that nothing moved. Because the recovered data must still match afterwards, this also shows that the idle cycle left the delay line untouched. From the 11th valid bit onward, the scrambler model's data is compared with bit_o at that same one-clock offset.

// File: rtl/nrzi_dscr_pkg.sv
package nrzi_dscr_pkg;
  parameter int unsigned DEF_TAP_NEAR = 4;
  parameter int unsigned DEF_TAP_FAR  = 9;
endpackage

// File: rtl/nrzi_to_nrz.sv
module nrzi_to_nrz (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic nrz_o
);
  logic hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hist_q <= 1'b0;
    else if (en_i) hist_q <= bit_i;
  end

  assign nrz_o = bit_i ^ hist_q;
endmodule

// File: rtl/ff_descrambler.sv
module ff_descrambler #(
  parameter int unsigned TAP_NEAR = 4,
  parameter int unsigned TAP_FAR  = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic nrz_i,
  output logic bit_o
);
  logic [TAP_FAR:1] dly_q;

  for (genvar g = 1; g <= TAP_FAR; g++) begin : g_stage
    logic d_in;
    if (g == 1) begin : g_head
      assign d_in = nrz_i;
    end else begin : g_body
      assign d_in = dly_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   dly_q[g] <= 1'b0;
      else if (en_i) dly_q[g] <= d_in;
    end
  end

  // multiply by x^TAP_FAR + x^TAP_NEAR + 1, no feedback
  assign bit_o = nrz_i ^ dly_q[TAP_NEAR] ^ dly_q[TAP_FAR];
endmodule

// File: rtl/settle_tracker.sv
module settle_tracker #(
  parameter int unsigned LEN = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic settle_o
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          settle_q;
  logic          filling;

  assign filling = (cnt_q < CW'(LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      settle_q <= 1'b1;
    end else if (en_i) begin
      settle_q <= filling;
      if (filling) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign settle_o = settle_q;
endmodule

// File: rtl/nrzi_descrambler.sv
module nrzi_descrambler
  import nrzi_dscr_pkg::*;
#(
  parameter int unsigned TAP_NEAR = DEF_TAP_NEAR,
  parameter int unsigned TAP_FAR  = DEF_TAP_FAR
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic bit_o,
  output logic bit_vld_o,
  output logic rpt_bit_o,
  output logic settle_o
);
  // one history stage plus the descrambler delay line
  localparam int unsigned SETTLE_LEN = TAP_FAR + 1;

  logic nrz;
  logic dscr;
  logic bit_q, vld_q, rpt_q;

  nrzi_to_nrz u_nrz (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (bit_vld_i),
    .bit_i (bit_i),
    .nrz_o (nrz)
  );

  ff_descrambler #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_dscr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (bit_vld_i),
    .nrz_i (nrz),
    .bit_o (dscr)
  );

  settle_tracker #(.LEN(SETTLE_LEN)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (bit_vld_i),
    .settle_o(settle_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
      rpt_q <= 1'b0;
    end else begin
      vld_q <= bit_vld_i;
      if (bit_vld_i) begin
        bit_q <= dscr;
        rpt_q <= bit_i;
      end
    end
  end

  assign bit_o     = bit_q;
  assign bit_vld_o = vld_q;
  assign rpt_bit_o = rpt_q;
endmodule

// File: rtl/nrzi_descrambler_chk.sv
module nrzi_descrambler_chk #(
  parameter int unsigned SETTLE_LEN = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_vld_i,
  input logic bit_i,
  input logic bit_o,
  input logic bit_vld_o,
  input logic rpt_bit_o,
  input logic settle_o
);
  logic [15:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (bit_vld_i && seen_q != 16'hFFFF) seen_q <= seen_q + 1'b1;
  end

  p_vld_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i |=> bit_vld_o);
  p_vld_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> !bit_vld_o);
  p_hold_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> $stable(bit_o) && $stable(rpt_bit_o));
  p_rpt_copy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i |=> rpt_bit_o == $past(bit_i));
  p_settle_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && seen_q >= 16'(SETTLE_LEN)) |=> !settle_o);
  p_settle_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && seen_q < 16'(SETTLE_LEN)) |=> settle_o);
endmodule

bind nrzi_descrambler nrzi_descrambler_chk #(.SETTLE_LEN(TAP_FAR + 1)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bit_vld_i(bit_vld_i),
  .bit_i    (bit_i),
  .bit_o    (bit_o),
  .bit_vld_o(bit_vld_o),
  .rpt_bit_o(rpt_bit_o),
  .settle_o (settle_o)
);

// File: tb/tb_nrzi_descrambler.sv
module tb_nrzi_descrambler;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_vld_i = 1'b0;
  logic bit_i = 1'b0;
  logic bit_o, bit_vld_o, rpt_bit_o, settle_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nrzi_descrambler dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o), .rpt_bit_o(rpt_bit_o), .settle_o(settle_o)
  );

  // {bit_i, expected bit_o, expected settle_o} after reset
  localparam logic [2:0] VEC [12] = '{
    3'b111, 3'b011, 3'b001, 3'b001, 3'b011, 3'b011,
    3'b001, 3'b001, 3'b001, 3'b011, 3'b010, 3'b000
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic b);
    bit_vld_i = v;
    bit_i = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    bit_vld_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 vld in reset", bit_vld_o, 0);
    check("R1 bit in reset", bit_o, 0);
    check("R1 rpt in reset", rpt_bit_o, 0);
    check("R1 settle in reset", settle_o, 1);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rng;
    logic [9:1]  sreg;
    logic        tprev, d, s, t, ob, orp;
    int          idx;

    do_reset();
    step(1'b0, 1'b0);
    check("R1 first cycle vld", bit_vld_o, 0);
    check("R1 first cycle settle", settle_o, 1);

    // table walk: impulse through NRZI and descrambler (R2, R3, R4, R6, R7)
    for (int k = 0; k < 12; k++) begin
      step(1'b1, VEC[k][2]);
      check($sformatf("R2/R3 bit_o vec %0d", k), bit_o, VEC[k][1]);
      check($sformatf("R4 vld vec %0d", k), bit_vld_o, 1);
      check($sformatf("R6 rpt vec %0d", k), rpt_bit_o, VEC[k][2]);
      check($sformatf("R7 settle vec %0d", k), settle_o, VEC[k][0]);
      if (k == 5) begin
        ob = bit_o;
        orp = rpt_bit_o;
        step(1'b0, 1'b1);
        check("R5 idle vld", bit_vld_o, 0);
        check("R5 idle bit hold", bit_o, ob);
        check("R5 idle rpt hold", rpt_bit_o, orp);
      end
    end

    // random data through matching scrambler model, with idle gaps (R8)
    do_reset();
    rng = 32'h1234_5678;
    sreg = 9'h1A5;
    tprev = 1'b1;
    idx = 0;
    while (idx < 3000) begin
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      if (rng[5:4] == 2'b00) begin
        ob = bit_o;
        orp = rpt_bit_o;
        step(1'b0, rng[9]);
        check("R5 idle vld", bit_vld_o, 0);
        check("R5 idle bit hold", bit_o, ob);
        check("R5 idle rpt hold", rpt_bit_o, orp);
      end else begin
        d = (idx >= 800 && idx < 1100) ? 1'b0 : rng[0];
        s = d ^ sreg[4] ^ sreg[9];
        sreg = {sreg[8:1], s};
        t = s ^ tprev;
        tprev = t;
        step(1'b1, t);
        check("R4 vld", bit_vld_o, 1);
        check("R6 rpt", rpt_bit_o, t);
        if (idx >= 10) check($sformatf("R8 data idx %0d", idx), bit_o, d);
        if (idx == 9 || idx == 10) check("R7 settle edge", settle_o, idx == 9 ? 1 : 0);
        idx++;
      end
    end

    // reset mid-stream re-arms settling
    do_reset();
    step(1'b1, 1'b1);
    check("R7 settle after re-reset", settle_o, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule